// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Barrier

This block sits beside one cache and takes invalidation messages from the coherence interconnect. Each message is acknowledged in the cycle it is taken, so the sender never waits for the cache. The target line is not touched at that point. Its line address is parked in a small queue and written to the tag state port later.

Queued entries leave the queue in arrival order, one per cycle, as `INVALID` writes to the tag state port. A write happens in any cycle the core leaves the tag port free. A load barrier can also force the writes. During a barrier the queue takes the tag port over the core and holds the core stalled until the queue is empty. A core lookup whose line matches a pending invalidation is reported as a miss, so stale data is never served. When the queue is full, new messages wait without an acknowledge.

Top module: `lazy_inval_queue`

## Requirements
- R1: While `inv_valid_i` is high and fewer than DEPTH entries are queued, `inv_ack_o` is high in the same cycle and the message is stored.
- R2: While DEPTH entries are queued, `inv_ack_o` stays low and nothing is stored. A held message is acknowledged in the first cycle after an entry has left.
- R3: Acceptance produces no tag write. Each applied entry drives `tag_we_o` high with `tag_line_o` = address bits [ADDR_W-1:6] and `tag_state_o` = 2'b00 (invalid; shared=01, exclusive=10, modified=11). Entries are applied in the order they were accepted.
- R4: With no barrier and `core_req_i` low, one queued entry is applied in every cycle until the queue is empty.
- R5: With no barrier active, `core_gnt_o` equals `core_req_i`, and no tag write happens while `core_req_i` is high.
- R6: A barrier is active from the cycle `lbar_req_i` is high until the queue has emptied. While it is active and entries remain, `lbar_stall_o` is high, `core_gnt_o` is low and one entry is applied per cycle.
- R7: `lbar_done_o` pulses for one cycle in the cycle after the last entry is applied. If the queue is already empty when the barrier is requested, it pulses in the request cycle with no stall.
- R8: A granted core lookup gives `core_miss_o` high when its line address (bits [ADDR_W-1:6]) equals a queued entry or a message accepted in the same cycle. The low 6 bits are ignored.
- R9: After reset the queue is empty, and `lbar_stall_o`, `lbar_done_o`, `tag_we_o` and `core_miss_o` are low.
- R10: The queue holds exactly DEPTH entries (default 8) before backpressure begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_valid_i | input | 1 | Invalidation message present |
| inv_addr_i | input | ADDR_W | Byte address of the line to invalidate |
| inv_ack_o | output | 1 | Message accepted this cycle |
| core_req_i | input | 1 | Core wants the tag port this cycle |
| core_addr_i | input | ADDR_W | Core lookup address |
| core_gnt_o | output | 1 | Core granted the tag port |
| core_miss_o | output | 1 | Force a miss on the granted lookup |
| lbar_req_i | input | 1 | Load barrier request |
| lbar_stall_o | output | 1 | Core stalled by barrier drain |
| lbar_done_o | output | 1 | Barrier complete pulse |
| tag_we_o | output | 1 | Tag state write strobe |
| tag_line_o | output | ADDR_W-6 | Line address being written |
| tag_state_o | output | 2 | State written, always invalid |

## Verification
Two overlaps are provoked on purpose. The first is a message arriving in the same cycle as a core lookup to the same line, with different low offset bits. That cycle must already report a miss, and so must the following cycle. The second is a full queue with a message held at its input while the queue drains. The bench checks that the held message is acknowledged in the cycle after the first entry leaves. That cycle has an enqueue and a dequeue together, and the bench checks that the arrival order of the applied lines is kept.

// File: rtl/inv_q_pkg.sv
package inv_q_pkg;
  typedef enum logic [1:0] {
    LS_INVALID   = 2'b00,
    LS_SHARED    = 2'b01,
    LS_EXCLUSIVE = 2'b10,
    LS_MODIFIED  = 2'b11
  } line_state_e;

  localparam int unsigned LINE_OFF = 6;
endpackage

// File: rtl/inv_q_store.sv
module inv_q_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              pop_i,
  output logic [LINE_W-1:0] head_line_o,
  output logic              empty_o,
  output logic              full_o,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              look_hit_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  hit_vec;
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign head_line_o = slot_q[rd_ptr_q];
  assign look_hit_o  = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTR_W'(g)) slot_q[g] <= push_line_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              vld_q[g] <= 1'b0;
      else if (push_i && wr_ptr_q == PTR_W'(g)) vld_q[g] <= 1'b1;
      else if (pop_i && rd_ptr_q == PTR_W'(g))  vld_q[g] <= 1'b0;
    end

    assign hit_vec[g] = vld_q[g] && (slot_q[g] == look_line_i);
  end
endmodule

// File: rtl/inv_q_ctrl.sv
module inv_q_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lbar_req_i,
  input  logic core_req_i,
  input  logic q_empty_i,
  output logic drain_o,
  output logic core_gnt_o,
  output logic stall_o,
  output logic done_o
);
  logic pend_q;
  logic bar_act;

  assign bar_act    = lbar_req_i | pend_q;
  assign stall_o    = bar_act & ~q_empty_i;
  assign done_o     = bar_act & q_empty_i;
  // barrier wins the tag port; otherwise drain only on idle core cycles
  assign drain_o    = ~q_empty_i & (stall_o | ~core_req_i);
  assign core_gnt_o = core_req_i & ~stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= stall_o;
  end
endmodule

// File: rtl/lazy_inval_queue.sv
module lazy_inval_queue
  import inv_q_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              inv_ack_o,
  input  logic              core_req_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  output logic              core_gnt_o,
  output logic              core_miss_o,
  input  logic              lbar_req_i,
  output logic              lbar_stall_o,
  output logic              lbar_done_o,
  output logic              tag_we_o,
  output logic [LINE_W-1:0] tag_line_o,
  output logic [1:0]        tag_state_o
);
  logic              q_empty, q_full, q_hit, drain;
  logic [LINE_W-1:0] inv_line, core_line;

  assign inv_line  = inv_addr_i[ADDR_W-1:LINE_OFF];
  assign core_line = core_addr_i[ADDR_W-1:LINE_OFF];
  assign inv_ack_o = inv_valid_i & ~q_full;

  inv_q_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (inv_ack_o),
    .push_line_i (inv_line),
    .pop_i       (drain),
    .head_line_o (tag_line_o),
    .empty_o     (q_empty),
    .full_o      (q_full),
    .look_line_i (core_line),
    .look_hit_o  (q_hit)
  );

  inv_q_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lbar_req_i (lbar_req_i),
    .core_req_i (core_req_i),
    .q_empty_i  (q_empty),
    .drain_o    (drain),
    .core_gnt_o (core_gnt_o),
    .stall_o    (lbar_stall_o),
    .done_o     (lbar_done_o)
  );

  assign tag_we_o    = drain;
  assign tag_state_o = LS_INVALID;
  // a line arriving this cycle is already pending for the lookup
  assign core_miss_o = core_gnt_o & (q_hit | (inv_ack_o & (inv_line == core_line)));
endmodule

// File: rtl/lazy_inval_queue_chk.sv
module lazy_inval_queue_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned LINE_W = ADDR_W - 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_valid_i,
  input logic [ADDR_W-1:0] inv_addr_i,
  input logic              inv_ack_o,
  input logic              core_req_i,
  input logic [ADDR_W-1:0] core_addr_i,
  input logic              core_gnt_o,
  input logic              core_miss_o,
  input logic              lbar_req_i,
  input logic              lbar_stall_o,
  input logic              lbar_done_o,
  input logic              tag_we_o,
  input logic [LINE_W-1:0] tag_line_o,
  input logic [1:0]        tag_state_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1) + 1;
  logic [CW-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + CW'(inv_ack_o) - CW'(tag_we_o);
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) occ_q <= CW'(DEPTH)); // R10
  AST_ACK_ROOM:     assert property (@(posedge clk_i) disable iff (!rst_ni) (inv_valid_i && occ_q < CW'(DEPTH)) |-> inv_ack_o); // R1
  AST_NO_ACK_FULL:  assert property (@(posedge clk_i) disable iff (!rst_ni) (occ_q == CW'(DEPTH)) |-> !inv_ack_o); // R2
  AST_NO_WR_EMPTY:  assert property (@(posedge clk_i) disable iff (!rst_ni) (occ_q == '0) |-> !tag_we_o); // R3
  AST_WR_INVALID:   assert property (@(posedge clk_i) disable iff (!rst_ni) tag_we_o |-> tag_state_o == 2'b00); // R3
  AST_IDLE_DRAIN:   assert property (@(posedge clk_i) disable iff (!rst_ni) (!core_req_i && occ_q != '0) |-> tag_we_o); // R4
  AST_CORE_PRIO:    assert property (@(posedge clk_i) disable iff (!rst_ni) (core_req_i && !lbar_stall_o) |-> (core_gnt_o && !tag_we_o)); // R5
  AST_STALL_DRAIN:  assert property (@(posedge clk_i) disable iff (!rst_ni) lbar_stall_o |-> (tag_we_o && !core_gnt_o)); // R6
  AST_DONE_EMPTY:   assert property (@(posedge clk_i) disable iff (!rst_ni) lbar_done_o |-> (occ_q == '0 && !lbar_stall_o)); // R7
  AST_MISS_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni) core_miss_o |-> core_gnt_o); // R8
endmodule

bind lazy_inval_queue lazy_inval_queue_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_lazy_inval_queue.sv
module sim_lazy_inval_queue;
  localparam int AW = 32;
  localparam int DP = 8;
  localparam int LW = AW - 6;
  localparam logic [AW-1:0] BASE = 32'h0000_4000;
  localparam logic [AW-1:0] BAR_BASE = 32'h0002_0000;
  localparam logic [AW-1:0] FAR  = 32'hFFFF_FFC0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 1'b0, core_req = 1'b0, lbar_req = 1'b0;
  logic [AW-1:0] inv_addr = '0, core_addr = '0;
  logic inv_ack, core_gnt, core_miss, lbar_stall, lbar_done, tag_we;
  logic [LW-1:0] tag_line;
  logic [1:0] tag_state;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lazy_inval_queue #(.ADDR_W(AW), .DEPTH(DP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .inv_valid_i(inv_valid), .inv_addr_i(inv_addr), .inv_ack_o(inv_ack),
    .core_req_i(core_req), .core_addr_i(core_addr), .core_gnt_o(core_gnt), .core_miss_o(core_miss),
    .lbar_req_i(lbar_req), .lbar_stall_o(lbar_stall), .lbar_done_o(lbar_done),
    .tag_we_o(tag_we), .tag_line_o(tag_line), .tag_state_o(tag_state)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic cyc();  // next cycle, drive window
    @(posedge clk); #2;
  endtask

  task automatic smp();  // sample window
    #6;
  endtask

  function automatic logic [LW-1:0] lof(input logic [AW-1:0] a);
    return a[AW-1:6];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    smp();
    // R9 reset state
    chk("R9 ack", inv_ack, 0); chk("R9 stall", lbar_stall, 0);
    chk("R9 done", lbar_done, 0); chk("R9 tag_we", tag_we, 0); chk("R9 miss", core_miss, 0);

    // fill with core busy: R1, R3 (no write at accept), R10
    for (int k = 0; k < DP; k++) begin
      cyc();
      core_req = 1; core_addr = FAR;
      inv_valid = 1; inv_addr = BASE + AW'(k * 64) + AW'((k * 7) % 64);
      smp();
      chk("R1 ack", inv_ack, 1);
      chk("R3 no write at accept", tag_we, 0);
      chk("R5 gnt", core_gnt, 1);
    end
    // R2 / R10 backpressure at DEPTH
    for (int h = 0; h < 3; h++) begin
      cyc();
      inv_addr = BASE + AW'(DP * 64) + 3;
      smp();
      chk("R10 full ack", inv_ack, 0);
      chk("R5 no write", tag_we, 0);
    end
    inv_valid = 0;
    // R8 sweep all offsets of queued and non-queued lines
    for (int k = 0; k <= DP; k++) begin
      for (int off = 0; off < 64; off++) begin
        cyc();
        core_addr = BASE + AW'(k * 64) + AW'(off);
        smp();
        chk("R8 miss", core_miss, (k < DP) ? 1 : 0);
        chk("R5 no write", tag_we, 0);
      end
    end
    // drain with held message: R2, R3 order, R4
    cyc();
    core_req = 0; inv_valid = 1; inv_addr = BASE + AW'(DP * 64) + 3;
    smp();
    chk("R2 held", inv_ack, 0);
    chk("R4 we", tag_we, 1);
    chk("R3 line", tag_line, lof(BASE));
    chk("R3 state", tag_state, 2'b00);
    cyc();
    smp();
    chk("R2 freed ack", inv_ack, 1);
    chk("R4 we", tag_we, 1);
    chk("R3 line", tag_line, lof(BASE + 64));
    for (int k = 2; k <= DP; k++) begin
      cyc();
      inv_valid = 0;
      smp();
      chk("R4 we", tag_we, 1);
      chk("R3 order", tag_line, lof(BASE + AW'(k * 64)));
    end
    cyc(); smp();
    chk("R4 empty", tag_we, 0);

    // barrier drain: R6, R7
    for (int k = 0; k < 3; k++) begin
      cyc();
      core_req = 1; core_addr = FAR;
      inv_valid = 1; inv_addr = BAR_BASE + AW'(k * 64) + AW'(k * 9);
      smp();
      chk("R1 ack", inv_ack, 1);
    end
    for (int k = 0; k < 3; k++) begin
      cyc();
      inv_valid = 0; lbar_req = (k == 0);
      smp();
      chk("R6 stall", lbar_stall, 1);
      chk("R6 gnt", core_gnt, 0);
      chk("R6 we", tag_we, 1);
      chk("R6 line", tag_line, lof(BAR_BASE + AW'(k * 64)));
      chk("R7 no done", lbar_done, 0);
    end
    cyc(); smp();
    chk("R7 done", lbar_done, 1);
    chk("R6 released", lbar_stall, 0);
    chk("R6 gnt back", core_gnt, 1);
    chk("R6 we idle", tag_we, 0);
    cyc(); smp();
    chk("R7 pulse", lbar_done, 0);

    // barrier on empty queue: R7
    cyc();
    lbar_req = 1;
    smp();
    chk("R7 empty done", lbar_done, 1);
    chk("R7 empty nostall", lbar_stall, 0);
    chk("R5 gnt", core_gnt, 1);
    cyc();
    lbar_req = 0;
    smp();
    chk("R7 pulse", lbar_done, 0);

    // same-cycle arrival and lookup: R8
    cyc();
    core_addr = BAR_BASE + 32'h1000 + 5;
    inv_valid = 1; inv_addr = BAR_BASE + 32'h1000 + 40;
    smp();
    chk("R1 ack", inv_ack, 1);
    chk("R8 same-cycle miss", core_miss, 1);
    cyc();
    inv_valid = 0;
    smp();
    chk("R8 queued miss", core_miss, 1);
    cyc();
    core_addr = BAR_BASE + 32'h1000 + 64;
    smp();
    chk("R8 neighbour line", core_miss, 0);
    cyc();
    core_addr = BAR_BASE + 32'h1000; lbar_req = 1;
    smp();
    chk("R6 stall", lbar_stall, 1);
    chk("R6 line", tag_line, lof(BAR_BASE + 32'h1000));
    chk("R8 stalled no miss", core_miss, 0);
    cyc();
    lbar_req = 0;
    smp();
    chk("R7 done", lbar_done, 1);
    chk("R8 after barrier", core_miss, 0);
    chk("R5 gnt", core_gnt, 1);
    cyc();
    core_req = 0;
    smp();
    chk("R4 empty idle", tag_we, 0);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule